// File: doc/BRIEF.md
# Group Address Hash Filter

This block sits beside a receive MAC. It decides whether an incoming frame's destination address falls into an enabled bin of a 256-bin group-address hash table. Address bytes arrive one per cycle on a strobed byte stream. A first-byte marker restarts the evaluation. A serial CRC-32 is folded over the six bytes as they arrive. When the sixth byte has been taken, an 8-bit bin number derived from the CRC selects one bit of the table. The block then emits a single-cycle verdict.

The table lives in eight 32-bit words that a controller loads through a plain write port. A promiscuous control input overrides the lookup and accepts everything. An address whose first byte has a clear least-significant bit is an individual address. Such an address never matches through the hash. At the start of each address the table is copied into a frozen working set, so table writes made during an evaluation cannot disturb it.

Top module: `mhf_filter`

## Requirements
- R1: After reset every table word is zero and `match_valid` is low; a group address evaluated with promiscuous mode off is then rejected.
- R2: The CRC register starts at 0xFFFFFFFF on the byte marked `da_first` and uses polynomial 0x04C11DB7 in shift-left form. Each byte is fed least-significant bit first, in arrival order, with no final inversion. The bin number is the top 8 bits of the bit-reversed CRC, so bin bit 7 equals CRC bit 0 and bin bit 0 equals CRC bit 7.
- R3: Bin bits [7:5] pick the table word, and bin bits [4:0] = n pick bit (31 - n) of that word. Bin 0 is bit 31 of word 0 and bin 255 is bit 0 of word 7.
- R4: A cycle with `cfg_we` high loads `cfg_data` into table word `cfg_sel`.
- R5: When the first address byte has bit 0 set, the address is accepted exactly when its bin bit is set. When that bit is clear, the address is rejected whatever the table holds, unless promiscuous mode applies.
- R6: If `promisc_en` is high in the cycle the sixth byte is taken, the verdict is accept.
- R7: `match_valid` pulses high for exactly one cycle, in the cycle after the clock edge that takes the sixth byte. Idle cycles between address bytes are allowed. `match_accept` is low whenever `match_valid` is low.
- R8: A byte with `da_first` high abandons any partial address and starts a new one. The abandoned address produces no verdict.
- R9: Bytes with `da_valid` high but `da_first` low, arriving when no address is in progress, are ignored. They produce no verdict.
- R10: A table write made while an address is being evaluated does not affect that address's verdict. It applies from the next address on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table word write strobe |
| cfg_sel | input | 3 | Table word number |
| cfg_data | input | 32 | Table word write data |
| promisc_en | input | 1 | Accept every address |
| da_valid | input | 1 | Address byte strobe |
| da_first | input | 1 | Marks the first address byte |
| da_byte | input | 8 | Address byte, first received byte first |
| match_valid | output | 1 | One-cycle verdict strobe |
| match_accept | output | 1 | Verdict: 1 accept, 0 reject |

## Verification
Any wrong bit in the CRC register, the byte counter or the frozen table appears at the ports the cycle after the sixth byte. It shows either as a verdict of the wrong polarity for an address whose bin the bench computed on its own, or as a verdict strobe that is missing, doubled or misplaced. The table-corner addresses for bins 0, 1, 254 and 255 expose swapped bit numbering or word selection on the first evaluation. A mid-address write exposes a table that is not frozen in the same verdict cycle.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    parameter int unsigned HASH_WORDS  = 8;
    parameter int unsigned HASH_WORD_W = 32;
    parameter int unsigned DA_BYTES    = 6;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    // position of one bin inside the table
    typedef struct packed {
        logic [$clog2(HASH_WORDS)-1:0]  word;
        logic [$clog2(HASH_WORD_W)-1:0] pos;
    } bin_loc_t;

    typedef struct packed {
        logic valid;
        logic accept;
    } verdict_t;

    // fold one byte into the CRC, least-significant data bit first
    function automatic logic [31:0] crc32_byte(input logic [31:0] c_in,
                                               input logic [7:0]  d);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[31] ^ d[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/mhf_crc_acc.sv
module mhf_crc_acc
    import mhf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        byte_en,
    input  logic        restart,
    input  logic [7:0]  byte_in,
    output logic [31:0] crc_after
);

    logic [31:0] crc_q;

    always_comb crc_after = crc32_byte(restart ? CRC_SEED : crc_q, byte_in);

    always_ff @(posedge clk) begin
        if (rst)          crc_q <= CRC_SEED;
        else if (byte_en) crc_q <= crc_after;
    end

    // R2
    crc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !byte_en |=> $stable(crc_q));

endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
    parameter int unsigned NUM_WORDS = 8,
    parameter int unsigned WORD_W    = 32,
    localparam int unsigned SEL_W    = $clog2(NUM_WORDS),
    localparam int unsigned POS_W    = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              freeze,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic [POS_W-1:0]  rd_pos,
    output logic              rd_bit
);

    logic [NUM_WORDS-1:0][WORD_W-1:0] prog_q;
    logic [NUM_WORDS-1:0][WORD_W-1:0] snap_q;
    logic [POS_W-1:0]                 flip_pos;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                prog_q[g] <= '0;
                snap_q[g] <= '0;
            end else begin
                if (wr_en && wr_sel == SEL_W'(g)) prog_q[g] <= wr_data;
                if (freeze)                       snap_q[g] <= prog_q[g];
            end
        end
    end

    // bit 0 of a word is its most significant bit
    always_comb begin
        flip_pos = POS_W'(WORD_W - 1) - rd_pos;
        rd_bit   = snap_q[rd_sel][flip_pos];
    end

    // R10
    snap_copy_chk: assert property (@(posedge clk) disable iff (rst)
        freeze |=> snap_q == $past(prog_q));

    // R10
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !freeze |=> $stable(snap_q));

endmodule

// File: rtl/mhf_filter.sv
module mhf_filter
    import mhf_pkg::*;
#(
    parameter int unsigned NUM_WORDS  = HASH_WORDS,
    parameter int unsigned WORD_W     = HASH_WORD_W,
    parameter int unsigned ADDR_BYTES = DA_BYTES,
    localparam int unsigned SEL_W     = $clog2(NUM_WORDS),
    localparam int unsigned POS_W     = $clog2(WORD_W),
    localparam int unsigned BIN_W     = SEL_W + POS_W,
    localparam int unsigned CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [WORD_W-1:0] cfg_data,
    input  logic              promisc_en,
    input  logic              da_valid,
    input  logic              da_first,
    input  logic [7:0]        da_byte,
    output logic              match_valid,
    output logic              match_accept
);

    logic [CNT_W-1:0] cnt_q;
    logic             grp_q;
    logic             take, cont, final_byte, grp_now, hit;
    logic [31:0]      crc_after;
    logic [BIN_W-1:0] bin;
    bin_loc_t         loc;
    verdict_t         verdict_q;

    // a new address starts on a marked byte; later bytes only count mid-address
    always_comb begin
        take       = da_valid && da_first;
        cont       = da_valid && !da_first && cnt_q != '0;
        final_byte = take ? (ADDR_BYTES == 1)
                          : (cont && cnt_q == CNT_W'(ADDR_BYTES - 1));
        grp_now    = take ? da_byte[0] : grp_q;
    end

    mhf_crc_acc u_crc (
        .clk      (clk),
        .rst      (rst),
        .byte_en  (take || cont),
        .restart  (take),
        .byte_in  (da_byte),
        .crc_after(crc_after)
    );

    // top bits of the bit-reversed CRC
    always_comb begin
        for (int i = 0; i < BIN_W; i++) bin[BIN_W-1-i] = crc_after[i];
        loc.word = bin[BIN_W-1 -: SEL_W];
        loc.pos  = bin[POS_W-1:0];
    end

    mhf_hash_table #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .wr_sel (cfg_sel),
        .wr_data(cfg_data),
        .freeze (take),
        .rd_sel (loc.word),
        .rd_pos (loc.pos),
        .rd_bit (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            grp_q     <= 1'b0;
            verdict_q <= '0;
        end else begin
            if (take) begin
                cnt_q <= final_byte ? '0 : CNT_W'(1);
                grp_q <= da_byte[0];
            end else if (cont) begin
                cnt_q <= final_byte ? '0 : cnt_q + CNT_W'(1);
            end
            verdict_q.valid  <= final_byte;
            verdict_q.accept <= final_byte && (promisc_en || (grp_now && hit));
        end
    end

    assign match_valid  = verdict_q.valid;
    assign match_accept = verdict_q.accept;

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        match_valid |=> !match_valid);

    // R7
    accept_qual_chk: assert property (@(posedge clk) disable iff (rst)
        match_accept |-> match_valid);

    // R6
    promisc_chk: assert property (@(posedge clk) disable iff (rst)
        match_valid && $past(promisc_en) |-> match_accept);

    // R5
    individual_chk: assert property (@(posedge clk) disable iff (rst)
        match_valid && !$past(promisc_en) && !$past(grp_now) |-> !match_accept);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(ADDR_BYTES));

endmodule

// File: tb/sim_mhf_filter.sv
`timescale 1ns/1ps
module sim_mhf_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_data = '0;
    logic        promisc_en = 1'b0;
    logic        da_valid = 1'b0;
    logic        da_first = 1'b0;
    logic [7:0]  da_byte = '0;
    logic        match_valid, match_accept;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [8];

    always #2 clk = ~clk;

    mhf_filter u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .promisc_en(promisc_en), .da_valid(da_valid),
        .da_first(da_first), .da_byte(da_byte), .match_valid(match_valid),
        .match_accept(match_accept)
    );

    task automatic chk(input logic ok, input string tag, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] c;
        logic [7:0]  b;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            b = a[47-8*i -: 8];
            for (int j = 0; j < 8; j++) begin
                fb = c[31] ^ b[j];
                c  = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        return c;
    endfunction

    function automatic logic [7:0] ref_bin(input logic [47:0] a);
        logic [31:0] c;
        logic [7:0]  r;
        c = ref_crc(a);
        for (int i = 0; i < 8; i++) r[7-i] = c[i];
        return r;
    endfunction

    function automatic logic bin_on(input logic [7:0] b);
        return model[b[7:5]][31 - b[4:0]];
    endfunction

    function automatic logic [47:0] find_addr(input logic [7:0] first, input logic [7:0] target);
        for (int k = 0; k < 65536; k++) begin
            if (ref_bin({first, 24'h005E00, 16'(k)}) == target)
                return {first, 24'h005E00, 16'(k)};
        end
        return '0;
    endfunction

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
        model[sel] = data;
    endtask

    task automatic set_bin(input logic [7:0] b);
        cfg_write(b[7:5], model[b[7:5]] | (32'h8000_0000 >> b[4:0]));
    endtask

    task automatic clear_all();
        for (int w = 0; w < 8; w++) cfg_write(3'(w), 32'h0);
    endtask

    // one full address; optional gap cycles and a table write during byte 2
    task automatic run_frame(input logic [47:0] a, input int gap, input logic prom,
                             input logic wr, input logic [2:0] wsel,
                             input logic [31:0] wdata, input string tag);
        logic exp_acc;
        exp_acc = prom || (a[40] && bin_on(ref_bin(a)));
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            da_valid = 1'b1; da_first = (i == 0); da_byte = a[47-8*i -: 8];
            promisc_en = prom;
            if (wr && i == 2) begin cfg_we = 1'b1; cfg_sel = wsel; cfg_data = wdata; end
            @(negedge clk);
            da_valid = 1'b0; da_first = 1'b0; cfg_we = 1'b0;
            if (i == 5) begin
                chk(match_valid === 1'b1, {tag, " R7 strobe"}, match_valid, 1'b1);
                chk(match_accept === exp_acc, {tag, " verdict"}, match_accept, exp_acc);
            end else begin
                chk(match_valid === 1'b0, {tag, " R7 early"}, match_valid, 1'b0);
                repeat (gap) @(negedge clk);
            end
        end
        promisc_en = 1'b0;
        if (wr) model[wsel] = wdata;
        @(negedge clk);
        chk(match_valid === 1'b0, {tag, " R7 width"}, match_valid, 1'b0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(match_valid === 1'b0, "R1 valid low", match_valid, 1'b0);
        run_frame(48'h0100_5E00_0001, 0, 1'b0, 1'b0, 3'd0, 32'h0, "R1 empty table");
    endtask

    task automatic t_basic();
        logic [47:0] a, b;
        a = 48'h0100_5E00_00FB;
        set_bin(ref_bin(a));
        run_frame(a, 0, 1'b0, 1'b0, 3'd0, 32'h0, "R2 R4 programmed bin");
        b = a;
        while (ref_bin(b) == ref_bin(a)) b[7:0] = b[7:0] + 8'd1;
        run_frame(b, 0, 1'b0, 1'b0, 3'd0, 32'h0, "R5 other bin");
        run_frame(a, 2, 1'b0, 1'b0, 3'd0, 32'h0, "R7 gapped bytes");
    endtask

    task automatic t_corners();
        logic [47:0] a0, a1, a254, a255;
        a0 = find_addr(8'h01, 8'd0);   a1 = find_addr(8'h01, 8'd1);
        a254 = find_addr(8'h01, 8'd254); a255 = find_addr(8'h01, 8'd255);
        clear_all();
        cfg_write(3'd0, 32'h8000_0000);
        run_frame(a0, 0, 1'b0, 1'b0, 3'd0, 32'h0, "R3 bin0 msb");
        run_frame(a1, 0, 1'b0, 1'b0, 3'd0, 32'h0, "R3 bin1 clear");
        cfg_write(3'd0, 32'h0);
        cfg_write(3'd7, 32'h0000_0001);
        run_frame(a255, 0, 1'b0, 1'b0, 3'd0, 32'h0, "R3 bin255 lsb");
        run_frame(a254, 0, 1'b0, 1'b0, 3'd0, 32'h0, "R3 bin254 clear");
        run_frame(a0, 0, 1'b0, 1'b0, 3'd0, 32'h0, "R4 bin0 rewritten");
    endtask

    task automatic t_individual();
        logic [47:0] u, g;
        clear_all();
        u = 48'h0012_3456_789A;
        set_bin(ref_bin(u));
        run_frame(u, 0, 1'b0, 1'b0, 3'd0, 32'h0, "R5 individual rejected");
        run_frame(u, 0, 1'b1, 1'b0, 3'd0, 32'h0, "R6 promisc individual");
        g = 48'h0100_5E7F_0001;
        while (bin_on(ref_bin(g))) g[7:0] = g[7:0] + 8'd1;
        run_frame(g, 1, 1'b1, 1'b0, 3'd0, 32'h0, "R6 promisc empty bin");
    endtask

    task automatic t_restart();
        logic [47:0] a;
        a = 48'h0100_5E00_00FB;
        clear_all();
        set_bin(ref_bin(a));
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            da_valid = 1'b1; da_first = (i == 0); da_byte = 8'h33 + 8'(i);
            @(negedge clk);
            da_valid = 1'b0; da_first = 1'b0;
            chk(match_valid === 1'b0, "R8 partial silent", match_valid, 1'b0);
        end
        run_frame(a, 0, 1'b0, 1'b0, 3'd0, 32'h0, "R8 restarted address");
    endtask

    task automatic t_stray();
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            da_valid = 1'b1; da_first = 1'b0; da_byte = 8'h01 + 8'(i);
            @(negedge clk);
            chk(match_valid === 1'b0, "R9 stray byte", match_valid, 1'b0);
        end
        da_valid = 1'b0;
        @(negedge clk);
        chk(match_valid === 1'b0, "R9 stray tail", match_valid, 1'b0);
        run_frame(48'h0100_5E00_00FB, 0, 1'b0, 1'b0, 3'd0, 32'h0, "R9 after stray");
    endtask

    task automatic t_midwrite();
        logic [47:0] a;
        logic [7:0]  b;
        a = 48'h0100_5E01_0203;
        b = ref_bin(a);
        clear_all();
        run_frame(a, 0, 1'b0, 1'b1, b[7:5], 32'h8000_0000 >> b[4:0], "R10 same address");
        run_frame(a, 0, 1'b0, 1'b0, 3'd0, 32'h0, "R10 next address");
    endtask

    initial begin
        for (int w = 0; w < 8; w++) model[w] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_corners();
        t_individual();
        t_restart();
        t_stray();
        t_midwrite();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule